// File: doc/BRIEF.md
# CHIP-8 Quirk-Configurable Execute Unit

This unit runs one group of CHIP-8 instructions whose results differ between interpreter generations. The group covers the 8xyN register ALU ops, the Fx55 and Fx65 register-block store and load, the Bnnn computed jump, and 2nnn call with 00EE return on a 16-entry hardware stack. The fetch stage supplies an already-fetched 16-bit opcode with a one-cycle start strobe. The unit raises a one-cycle done pulse when the instruction has finished. A static quirk vector selects each compatibility behaviour on its own. With the whole vector at zero, the unit follows the first interpreter exactly.

Register-block transfers move one byte per clock over a synchronous memory port. Write data is taken at the clock edge. Read data appears one cycle after the address. A read port lets the surrounding core, or a test, see any V register. The program counter, the index register I, the stack pointer and a sticky stack-fault flag are visible on output ports.

Top module: `c8_exec_unit`

## Requirements
- R1: 8xy0 copies Vy to Vx. 8xy4 writes Vx+Vy mod 256 to Vx and sets VF to the carry. 8xy5 writes Vx-Vy and 8xy7 writes Vy-Vx, and each sets VF to 1 when its subtraction does not borrow (minuend >= subtrahend), else to 0. Any other low nibble changes no register.
- R2: 8xy6 shifts right and 8xyE shifts left. The source is Vy when quirk bit 0 is clear, and Vx when it is set. The result goes to Vx. VF receives the bit shifted out: bit 0 of the source for 8xy6, bit 7 for 8xyE.
- R3: 8xy1 (OR), 8xy2 (AND) and 8xy3 (XOR) write the result to Vx. They also clear VF when quirk bit 1 is clear. When quirk bit 1 is set, they leave VF untouched.
- R4: When an ALU op writes both a result and a flag and x is F, VF ends up holding the flag.
- R5: Fx55 writes V0..Vx to memory at addresses I..I+x, one byte per clock, in ascending order. Done rises x+2 clock edges after the start edge.
- R6: Fx65 fills V0..Vx from memory at addresses I..I+x. Done rises x+3 clock edges after the start edge.
- R7: After Fx55 or Fx65, I becomes I+x+1 when quirk bits 2 and 3 are both clear. It becomes I+x when bit 2 is set. It stays unchanged when bit 3 is set. The new I is taken modulo 4096, or modulo 65536 when quirk bit 6 is set.
- R8: Bnnn sets the PC to nnn+V0. With quirk bit 4 set, it sets the PC to nnn+Vx instead, where x is opcode bits 11:8. The target is taken modulo 4096 unless quirk bit 6 is set.
- R9: 2nnn pushes the current PC, sets the PC to nnn and increments the stack pointer. 00EE pops the most recent entry into the PC and decrements the stack pointer.
- R10: With quirk bit 5 clear, a call onto a full stack (16 entries) or a return from an empty stack sets a fault flag. The fault flag stays set until reset. The PC and stack pointer stay unchanged.
- R11: With quirk bit 5 set, the 4-bit stack pointer wraps modulo 16 on push and on pop, and no fault is raised.
- R12: After reset the PC is 0x200, I is 0, the stack pointer is 0, every V register is 0, and fault and done are low.
- R13: ALU, jump, call and return ops finish in one cycle: done is high in the cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; taken only while the unit is idle |
| opcode_i | input | 16 | Instruction to execute, valid with start_i |
| quirk_i | input | 7 | Static compatibility flags (bit meanings in R2, R3, R7, R8, R10, R11) |
| done_o | output | 1 | One-cycle pulse when the instruction finishes |
| mem_addr_o | output | 16 | Memory address for block transfers |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |
| rd_sel_i | input | 4 | Register read select |
| rd_data_o | output | 8 | Contents of the selected V register |
| pc_o | output | 16 | Program counter |
| idx_o | output | 16 | Index register I |
| sp_o | output | 4 | Stack pointer |
| fault_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
A wrong transfer counter shows up in one of two ways. It writes the wrong bytes into memory on the following edges, or it shifts the done pulse away from the fixed x+2 or x+3 latency, so the error appears before the instruction completes. A corrupt I value or a wrong stack level is hidden until a later instruction depends on it. A later transfer then lands at a wrong address, or a return restores a wrong PC or fails to flag a fault. For this reason the checks chain instructions together, including runs long enough to wrap I and to fill the stack. An ALU error in the flag or result shows up on the read port in the cycle after done.

// File: rtl/c8_exec_pkg.sv
package c8_exec_pkg;
  localparam int QUIRK_W   = 7;
  localparam int Q_SHIFT_VX = 0;
  localparam int Q_KEEP_VF  = 1;
  localparam int Q_INC_X    = 2;
  localparam int Q_NO_INC   = 3;
  localparam int Q_JUMP_VX  = 4;
  localparam int Q_CYCLIC   = 5;
  localparam int Q_WIDE     = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_LOAD, ST_TAIL} xstate_e;
endpackage

// File: rtl/c8_alu.sv
module c8_alu (
  input  logic [3:0] op_i,
  input  logic [7:0] vx_i,
  input  logic [7:0] vy_i,
  input  logic       shift_vx_i,
  input  logic       keep_vf_i,
  output logic [7:0] res_o,
  output logic       flag_o,
  output logic       wr_res_o,
  output logic       wr_flag_o
);
  logic [7:0] src;
  logic [8:0] sum;

  assign src = shift_vx_i ? vx_i : vy_i;
  assign sum = {1'b0, vx_i} + {1'b0, vy_i};

  always_comb begin
    res_o     = 8'h00;
    flag_o    = 1'b0;
    wr_res_o  = 1'b1;
    wr_flag_o = 1'b1;
    unique case (op_i)
      4'h0: begin res_o = vy_i; wr_flag_o = 1'b0; end
      4'h1: begin res_o = vx_i | vy_i; wr_flag_o = ~keep_vf_i; end
      4'h2: begin res_o = vx_i & vy_i; wr_flag_o = ~keep_vf_i; end
      4'h3: begin res_o = vx_i ^ vy_i; wr_flag_o = ~keep_vf_i; end
      4'h4: begin res_o = sum[7:0]; flag_o = sum[8]; end
      4'h5: begin res_o = vx_i - vy_i; flag_o = (vx_i >= vy_i); end
      4'h6: begin res_o = {1'b0, src[7:1]}; flag_o = src[0]; end
      4'h7: begin res_o = vy_i - vx_i; flag_o = (vy_i >= vx_i); end
      4'hE: begin res_o = {src[6:0], 1'b0}; flag_o = src[7]; end
      default: begin wr_res_o = 1'b0; wr_flag_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/c8_call_stack.sv
module c8_call_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int SPW  = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic           cyclic_i,
  input  logic [W-1:0]   push_data_i,
  output logic [W-1:0]   top_o,
  output logic           accept_o,
  output logic [SPW-1:0] sp_o,
  output logic           fault_o
);
  // DEPTH must be a power of two so the pointer wraps naturally
  localparam logic [SPW:0] FULL_LVL = (SPW+1)'(DEPTH);

  logic [W-1:0]   mem_q [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [SPW:0]   lvl_q;
  logic           fault_q;
  logic           full, empty, push_ok, pop_ok;

  assign full     = (lvl_q == FULL_LVL);
  assign empty    = (lvl_q == '0);
  assign push_ok  = push_i && (cyclic_i || !full);
  assign pop_ok   = pop_i && (cyclic_i || !empty);
  assign accept_o = push_ok || pop_ok;
  assign top_o    = mem_q[sp_q - 1'b1];
  assign sp_o     = sp_q;
  assign fault_o  = fault_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[sp_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= '0;
      lvl_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      if (push_ok) begin
        sp_q <= sp_q + 1'b1;
        if (!full) lvl_q <= lvl_q + 1'b1;
      end else if (pop_ok) begin
        sp_q <= sp_q - 1'b1;
        if (!empty) lvl_q <= lvl_q - 1'b1;
      end
      if ((push_i && !push_ok) || (pop_i && !pop_ok)) fault_q <= 1'b1;
    end
  end

  // R10
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |=> fault_q);
  // R10
  sp_hold_on_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((push_i || pop_i) && !accept_o) |=> $stable(sp_q));
endmodule

// File: rtl/c8_exec_unit.sv
module c8_exec_unit
  import c8_exec_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int STACK_DEPTH = 16,
  localparam int SPW        = $clog2(STACK_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [15:0]        opcode_i,
  input  logic [QUIRK_W-1:0] quirk_i,
  output logic               done_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_we_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [7:0]         mem_rdata_i,
  input  logic [3:0]         rd_sel_i,
  output logic [7:0]         rd_data_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [ADDR_W-1:0]  idx_o,
  output logic [SPW-1:0]     sp_o,
  output logic               fault_o
);
  localparam logic [ADDR_W-1:0] PC_RESET    = ADDR_W'(16'h0200);
  localparam logic [ADDR_W-1:0] NARROW_MASK = ADDR_W'(16'h0FFF);

  xstate_e          state_q;
  logic [7:0]       regs_q [16];
  logic [ADDR_W-1:0] pc_q, idx_q, idx_next, amask, jmp_tgt, stk_top;
  logic [3:0]       cnt_q, xr_q;
  logic             done_q;

  logic [3:0] nib, ox, oy, on;
  logic [11:0] nnn;
  logic [7:0] kk;
  assign nib = opcode_i[15:12];
  assign ox  = opcode_i[11:8];
  assign oy  = opcode_i[7:4];
  assign on  = opcode_i[3:0];
  assign nnn = opcode_i[11:0];
  assign kk  = opcode_i[7:0];

  logic idle_go;
  assign idle_go = start_i && (state_q == ST_IDLE);
  assign amask   = quirk_i[Q_WIDE] ? '1 : NARROW_MASK;

  logic [7:0] alu_res;
  logic       alu_flag, alu_wr_res, alu_wr_flag;

  c8_alu u_alu (
    .op_i       (on),
    .vx_i       (regs_q[ox]),
    .vy_i       (regs_q[oy]),
    .shift_vx_i (quirk_i[Q_SHIFT_VX]),
    .keep_vf_i  (quirk_i[Q_KEEP_VF]),
    .res_o      (alu_res),
    .flag_o     (alu_flag),
    .wr_res_o   (alu_wr_res),
    .wr_flag_o  (alu_wr_flag)
  );

  logic stk_push, stk_pop, stk_ok;
  assign stk_push = idle_go && (nib == 4'h2);
  assign stk_pop  = idle_go && (opcode_i == 16'h00EE);

  c8_call_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (stk_push),
    .pop_i       (stk_pop),
    .cyclic_i    (quirk_i[Q_CYCLIC]),
    .push_data_i (pc_q),
    .top_o       (stk_top),
    .accept_o    (stk_ok),
    .sp_o        (sp_o),
    .fault_o     (fault_o)
  );

  // jump base: V0 with NNN, or Vx with XNN under the jump quirk
  logic [7:0] jmp_reg;
  assign jmp_reg = quirk_i[Q_JUMP_VX] ? regs_q[ox] : regs_q[0];
  assign jmp_tgt = (ADDR_W'(nnn) + ADDR_W'(jmp_reg)) & amask;

  always_comb begin
    if (quirk_i[Q_NO_INC])     idx_next = idx_q;
    else if (quirk_i[Q_INC_X]) idx_next = (idx_q + ADDR_W'(xr_q)) & amask;
    else                       idx_next = (idx_q + ADDR_W'(xr_q) + 1'b1) & amask;
  end

  assign mem_addr_o  = (idx_q + ADDR_W'(cnt_q)) & amask;
  assign mem_we_o    = (state_q == ST_STORE);
  assign mem_wdata_o = regs_q[cnt_q];
  assign rd_data_o   = regs_q[rd_sel_i];
  assign pc_o        = pc_q;
  assign idx_o       = idx_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= PC_RESET;
      idx_q   <= '0;
      cnt_q   <= '0;
      xr_q    <= '0;
      done_q  <= 1'b0;
      for (int i = 0; i < 16; i++) regs_q[i] <= 8'h00;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cnt_q <= '0;
          xr_q  <= ox;
          if (nib == 4'hF && kk == 8'h55)      state_q <= ST_STORE;
          else if (nib == 4'hF && kk == 8'h65) state_q <= ST_LOAD;
          else begin
            done_q <= 1'b1;
            if (nib == 4'h8) begin
              if (alu_wr_res)  regs_q[ox]   <= alu_res;
              if (alu_wr_flag) regs_q[4'hF] <= alu_flag ? 8'h01 : 8'h00;
            end else if (nib == 4'hB) begin
              pc_q <= jmp_tgt;
            end else if (stk_push && stk_ok) begin
              pc_q <= ADDR_W'(nnn);
            end else if (stk_pop && stk_ok) begin
              pc_q <= stk_top & amask;
            end
          end
        end
        ST_STORE: begin
          if (cnt_q == xr_q) begin
            idx_q   <= idx_next;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_LOAD: begin
          if (cnt_q != 4'h0) regs_q[cnt_q - 1'b1] <= mem_rdata_i;
          if (cnt_q == xr_q) state_q <= ST_TAIL;
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_TAIL: begin
          regs_q[xr_q] <= mem_rdata_i;
          idx_q   <= idx_next;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STORE && $past(state_q) == ST_STORE)
      |-> mem_addr_o == (($past(mem_addr_o) + 1'b1) & amask));
  // R7
  idx_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(idx_q) |-> done_q);
  // R9
  pc_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_q) |-> done_q);
  // R13
  alu_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_go && nib == 4'h8) |=> done_q);
endmodule

// File: tb/c8_exec_unit_test.sv
`timescale 1ns/1ps
module c8_exec_unit_test;
  localparam logic [6:0] Q_SHIFT = 7'h01, Q_LOGIC = 7'h02, Q_INCX = 7'h04,
                         Q_NOINC = 7'h08, Q_JMP = 7'h10, Q_CYC = 7'h20, Q_WIDE = 7'h40;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] opcode = 16'h0000;
  logic [6:0]  quirk = 7'h00;
  logic        done, mem_we;
  logic [15:0] mem_addr, pc, idx;
  logic [7:0]  mem_wdata, mem_rdata = 8'h00, rd_data;
  logic [3:0]  rd_sel = 4'h0, sp;
  logic        fault;
  logic [7:0]  mem [256];
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  c8_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode), .quirk_i(quirk),
    .done_o(done), .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .pc_o(pc),
    .idx_o(idx), .sp_o(sp), .fault_o(fault));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; start = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic exec(input logic [15:0] op, input logic [6:0] q, output int cyc);
    @(negedge clk);
    opcode = op; quirk = q; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R13 op %0h never done actual=%0d expected=done", op, cyc);
    end
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] v);
    rd_sel = s; #0.5; v = rd_data;
  endtask

  function automatic void alu_ref(input logic [3:0] op, input logic [7:0] vx, vy, vf,
                                  input bit sq, lq, output logic [7:0] rx, rf);
    logic [7:0] s; logic [8:0] t;
    s = sq ? vx : vy; rx = vx; rf = vf;
    case (op)
      4'h0: rx = vy;
      4'h1: begin rx = vx | vy; if (!lq) rf = 0; end
      4'h2: begin rx = vx & vy; if (!lq) rf = 0; end
      4'h3: begin rx = vx ^ vy; if (!lq) rf = 0; end
      4'h4: begin t = vx + vy; rx = t[7:0]; rf = {7'd0, t[8]}; end
      4'h5: begin rx = vx - vy; rf = (vx >= vy) ? 1 : 0; end
      4'h6: begin rx = s >> 1; rf = {7'd0, s[0]}; end
      4'h7: begin rx = vy - vx; rf = (vy >= vx) ? 1 : 0; end
      4'hE: begin rx = s << 1; rf = {7'd0, s[7]}; end
      default: ;
    endcase
  endfunction

  initial begin
    #760000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] vals [8];
    logic [3:0] ops [9];
    logic [7:0] v, ex, ef;
    int cyc;
    vals = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h7F, 8'h80, 8'hFE, 8'hFF};
    ops  = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hE};
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    do_reset();
    // R12 reset state
    chk("R12 pc", pc, 16'h0200);
    chk("R12 idx", idx, 0);
    chk("R12 sp", sp, 0);
    chk("R12 fault", fault, 0);
    chk("R12 done", done, 0);
    rd(4'h0, v); chk("R12 V0", v, 0);
    rd(4'hF, v); chk("R12 VF", v, 0);

    // R1 R2 R3 R13: ALU sweep, x=1 y=2, VF preset 5A
    for (int qm = 0; qm < 2; qm++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          for (int o = 0; o < 9; o++) begin
            mem[1] = vals[a]; mem[2] = vals[b]; mem[15] = 8'h5A;
            exec(16'hFF65, Q_NOINC, cyc);
            exec({4'h8, 4'h1, 4'h2, ops[o]}, qm ? (Q_SHIFT | Q_LOGIC | Q_NOINC) : Q_NOINC, cyc);
            chk("R13 alu latency", cyc, 1);
            alu_ref(ops[o], vals[a], vals[b], 8'h5A, qm == 1, qm == 1, ex, ef);
            rd(4'h1, v);
            if (ops[o] == 4'h6 || ops[o] == 4'hE) chk("R2 shift result", v, ex);
            else if (ops[o] inside {4'h1, 4'h2, 4'h3}) chk("R3 logic result", v, ex);
            else chk("R1 arith result", v, ex);
            rd(4'hF, v);
            if (ops[o] == 4'h6 || ops[o] == 4'hE) chk("R2 shift flag", v, ef);
            else if (ops[o] inside {4'h1, 4'h2, 4'h3}) chk("R3 logic VF", v, ef);
            else chk("R1 arith flag", v, ef);
          end

    // R4: x = F, flag wins over result
    for (int a = 0; a < 8; a++)
      for (int o = 0; o < 9; o++) begin
        mem[2] = vals[7 - a]; mem[15] = vals[a];
        exec(16'hFF65, Q_NOINC, cyc);
        exec({4'h8, 4'hF, 4'h2, ops[o]}, Q_NOINC, cyc);
        alu_ref(ops[o], vals[a], vals[7 - a], vals[a], 1'b0, 1'b0, ex, ef);
        rd(4'hF, v);
        if (ops[o] inside {4'h4, 4'h5, 4'h6, 4'h7, 4'hE}) chk("R4 VF holds flag", v, ef);
        else chk("R4 VF result", v, (ops[o] == 4'h0) ? ex : ef);
      end

    // R5 R6 R7 block transfers
    do_reset();
    for (int i = 0; i < 16; i++) mem[i] = 8'h10 + 8'(i);
    exec(16'hFF65, Q_NOINC, cyc);
    chk("R6 load latency", cyc, 18);
    chk("R7 no-inc", idx, 0);
    for (int i = 0; i < 16; i++) begin rd(4'(i), v); chk("R6 loaded reg", v, 8'h10 + 8'(i)); end
    for (int i = 0; i < 12; i++) mem[i] = 8'h00;
    exec(16'hF555, 7'h00, cyc);
    chk("R5 store latency", cyc, 7);
    chk("R7 base inc", idx, 6);
    for (int i = 0; i < 6; i++) chk("R5 stored byte", mem[i], 8'h10 + 8'(i));
    chk("R5 beyond x untouched", mem[6], 0);
    exec(16'hF355, Q_INCX, cyc);
    chk("R7 inc by x", idx, 9);
    for (int i = 0; i < 4; i++) chk("R5 stored at I", mem[6 + i], 8'h10 + 8'(i));
    mem[10] = 8'hA0; mem[11] = 8'hA1;
    exec(16'hF265, Q_NOINC, cyc);
    chk("R6 load latency x2", cyc, 5);
    chk("R7 no-inc", idx, 9);
    rd(4'h0, v); chk("R6 V0", v, 8'h13);
    rd(4'h1, v); chk("R6 V1", v, 8'hA0);
    rd(4'h2, v); chk("R6 V2", v, 8'hA1);
    rd(4'h3, v); chk("R6 V3 untouched", v, 8'h13);
    exec(16'hF065, 7'h00, cyc);
    chk("R6 load latency x0", cyc, 3);
    chk("R7 x0 base", idx, 10);

    // R7 wrap at 4 KiB and 64 KiB
    for (int w = 0; w < 2; w++) begin
      do_reset();
      for (int i = 0; i < 255; i++) exec(16'hFF65, w ? Q_WIDE : 7'h00, cyc);
      chk("R7 climb", idx, 16'h0FF0);
      exec(16'hFF55, w ? Q_WIDE : 7'h00, cyc);
      chk("R7 wrap width", idx, w ? 16'h1000 : 16'h0000);
    end

    // R8 jumps
    for (int w = 0; w < 2; w++)
      for (int j = 0; j < 2; j++)
        for (int a = 0; a < 8; a++) begin
          logic [11:0] t;
          logic [16:0] s;
          do_reset();
          t = 12'h0F0 + 12'(a) * 12'h1F3;
          mem[0] = vals[a]; mem[t[11:8]] = vals[7 - a];
          if (t[11:8] == 4'h0) mem[0] = vals[a];
          exec(16'hFF65, Q_NOINC, cyc);
          exec({4'hB, t}, (w ? Q_WIDE : 7'h00) | (j ? Q_JMP : 7'h00), cyc);
          s = 17'(t) + 17'(j ? mem[t[11:8]] : mem[0]);
          chk("R8 jump target", pc, w ? s[15:0] : {4'h0, s[11:0]});
          chk("R13 jump latency", cyc, 1);
        end

    // R9 R10 call/return, non-cyclic
    do_reset();
    exec(16'h2ABC, 7'h00, cyc);
    chk("R9 call pc", pc, 16'h0ABC); chk("R9 sp", sp, 1);
    exec(16'h2123, 7'h00, cyc);
    chk("R9 call pc", pc, 16'h0123); chk("R9 sp", sp, 2);
    exec(16'h00EE, 7'h00, cyc);
    chk("R9 ret pc", pc, 16'h0ABC); chk("R9 sp", sp, 1);
    exec(16'h00EE, 7'h00, cyc);
    chk("R9 ret pc", pc, 16'h0200); chk("R9 sp", sp, 0);
    chk("R10 no fault yet", fault, 0);
    exec(16'h00EE, 7'h00, cyc);
    chk("R10 underflow fault", fault, 1);
    chk("R10 sp held", sp, 0); chk("R10 pc held", pc, 16'h0200);
    exec(16'h2300, 7'h00, cyc);
    chk("R10 fault sticky", fault, 1);

    do_reset();
    for (int i = 0; i < 16; i++) exec(16'h2100 + 16'(i), 7'h00, cyc);
    chk("R10 full no fault", fault, 0);
    exec(16'h2777, 7'h00, cyc);
    chk("R10 overflow fault", fault, 1);
    chk("R10 pc held", pc, 16'h010F); chk("R10 sp held", sp, 0);
    exec(16'h00EE, 7'h00, cyc);
    chk("R9 ret from full", pc, 16'h010E);

    // R11 cyclic
    do_reset();
    for (int i = 0; i < 17; i++) exec(16'h2100 + 16'(i), Q_CYC, cyc);
    chk("R11 wrap sp", sp, 1); chk("R11 no fault", fault, 0);
    chk("R11 pc", pc, 16'h0110);
    exec(16'h00EE, Q_CYC, cyc);
    chk("R11 ret pc", pc, 16'h010F); chk("R11 sp", sp, 0);
    exec(16'h00EE, Q_CYC, cyc);
    chk("R11 ret wrap pc", pc, 16'h010E); chk("R11 sp under", sp, 15);
    chk("R11 no fault", fault, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule